// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes received frames as a byte stream and stores them one after another in a circular region of memory, through a 32-bit write port with byte enables. Every stored frame is preceded by a 4-byte header: a 16-bit status in the low half and a 16-bit length in the high half, both little-endian. While a frame is being copied, its header reads as busy. The real header is written only once the last byte has arrived. The hardware write pointer then advances past the frame to the next 4-byte boundary.

The host consumes frames and reports its progress by writing a read-pointer register. That register holds the read offset minus 16. The block adds the bias back when it compares the two pointers, and uses the result both for the buffer-empty flag and for the free-space test that protects unread data. A frame that does not fit is discarded, counted and signalled with a one-cycle overflow pulse.

Address classes (broadcast, physical match, multicast) and receive error flags are decided upstream. They arrive with the final byte, and the block applies its acceptance mask to them. The input stream uses valid/ready. A byte transfers on a rising edge where both are high. `in_valid` may be held for any length of time, and `in_ready` drops for one cycle before each frame while the busy header is written, and for one cycle after it while the final header is written. Output addresses are byte offsets from the start of the ring.

Top module: `rx_ring_writer`

## Requirements
- R1: The ring length is 2^(RING_MIN_LOG+code) bytes, where code is configuration bits [12:11]. All write addresses, the write pointer and the biased read offset wrap modulo this length.
- R2: The first memory write of a stored frame goes to the write pointer with data 32'hFFF0_0000: length half 0xFFF0, status half zero. This marks the frame as still being copied.
- R3: Frame byte i is written at offset (write pointer + 4 + i) modulo the ring length, with byte i in lane i mod 4 of the 32-bit word. A partial final word enables only its valid lanes, and every write address is a multiple of 4.
- R4: After the last byte, the header word at the write pointer is rewritten. Bits [31:16] hold the frame's byte count, which includes the trailing CRC. Bits [15:0] hold the status.
- R5: Status bit 0 is set when in_err is all zero, bits [5:1] copy in_err[4:0], bit 13 is broadcast, bit 14 is physical match and bit 15 is multicast. All other bits are zero.
- R6: After a stored frame of N bytes, the write pointer becomes (pointer + 4 + N rounded up to a multiple of 4) modulo the ring length. wr_ptr is always a multiple of 4.
- R7: The read-pointer register resets to 0xFFF0. The read offset is (register + 16) modulo the ring length, and buf_empty is high exactly when the read offset equals the write pointer.
- R8: A frame is stored when any of these holds: accept bit 0 (all frames) is set; bit 1 is set and in_phys is high; bit 2 is set and in_mcast is high; bit 3 is set and in_bcast is high. Otherwise the write pointer and the miss count stay unchanged.
- R9: A frame is discarded as missed when 4 plus its length rounded up to 4 is not smaller than the free space. Free space is (read offset − write pointer) modulo the ring length, or the full length when the two are equal. A missed frame leaves the write pointer unchanged, adds one to miss_count and raises ovf_irq for exactly one cycle. This check is made before the filter.
- R10: While rx_en is low, in_ready is low and the write pointer returns to 0. Configuration writes take effect only while rx_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Accept mask [3:0], ring length code [12:11] |
| rdp_we | input | 1 | Host read-pointer write strobe |
| rdp_wdata | input | 16 | New host read pointer (offset − 16) |
| in_valid | input | 1 | Byte valid |
| in_ready | output | 1 | Byte accepted this cycle when valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of frame |
| in_err | input | 5 | Receive error flags, valid with in_last |
| in_bcast | input | 1 | Broadcast destination, valid with in_last |
| in_phys | input | 1 | Physical address match, valid with in_last |
| in_mcast | input | 1 | Multicast destination, valid with in_last |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Byte offset within the ring, multiple of 4 |
| mem_wdata | output | 32 | Write data, little-endian lanes |
| mem_be | output | 4 | Lane enables |
| rd_ptr | output | 16 | Host read-pointer register |
| wr_ptr | output | 16 | Current write offset |
| buf_empty | output | 1 | Read offset equals write offset |
| ovf_irq | output | 1 | One-cycle pulse per missed frame |
| miss_count | output | 16 | Missed-frame count |

## Verification
The bench builds the block with RING_MIN_LOG set to 6, so the four length codes give rings of 64 to 512 bytes. With frames of up to 60 bytes, wrap-around of headers and data, exact-fit overflow boundaries and repeated misses all occur within a few dozen frames. Random epochs change the length code and the acceptance mask. They vary whether the host drains the ring between frames, which stresses the biased read-pointer arithmetic against a bench-side model of free space.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_DROP = 2'd2,
    ST_HDR  = 2'd3
  } rxr_state_e;

  localparam int unsigned ACC_ALL   = 0;
  localparam int unsigned ACC_PHYS  = 1;
  localparam int unsigned ACC_MCAST = 2;
  localparam int unsigned ACC_BCAST = 3;
  localparam int unsigned SZ_LO     = 11;
  localparam int unsigned SZ_HI     = 12;

  localparam logic [15:0] LEN_BUSY = 16'hFFF0;
  localparam logic [15:0] PTR_BIAS = 16'd16;

  function automatic logic [15:0] make_status(input logic [4:0] err,
                                              input logic bcast,
                                              input logic phys,
                                              input logic mcast);
    logic [15:0] s;
    s       = '0;
    s[0]    = (err == 5'd0);
    s[5:1]  = err;
    s[13]   = bcast;
    s[14]   = phys;
    s[15]   = mcast;
    return s;
  endfunction

endpackage

// File: rtl/rxr_cfg.sv
module rxr_cfg
  import rxr_pkg::*;
#(
  parameter int unsigned MIN_LOG = 13,
  localparam int unsigned AW = MIN_LOG + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          cfg_we,
  input  logic [15:0]   cfg_wdata,
  input  logic          rdp_we,
  input  logic [15:0]   rdp_wdata,
  output logic [3:0]    accept,
  output logic [AW-1:0] mask,
  output logic [AW:0]   ring_len,
  output logic [15:0]   rd_ptr
);

  logic [1:0] size_code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept    <= '0;
      size_code <= '0;
      rd_ptr    <= LEN_BUSY;
    end else begin
      if (cfg_we && rx_en) begin
        accept    <= cfg_wdata[3:0];
        size_code <= cfg_wdata[SZ_HI:SZ_LO];
      end
      if (rdp_we) rd_ptr <= rdp_wdata;
    end
  end

  always_comb begin
    ring_len = '0;
    ring_len[MIN_LOG + 32'(size_code)] = 1'b1;
    mask     = AW'(ring_len - 1'b1);
  end

endmodule

// File: rtl/rxr_space.sv
module rxr_space
  import rxr_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic [15:0]   rd_ptr,
  input  logic [AW-1:0] wptr,
  input  logic [AW-1:0] mask,
  input  logic [AW:0]   ring_len,
  output logic [AW:0]   free_bytes,
  output logic          empty
);

  logic [15:0]   biased;
  logic [AW-1:0] rd_off;
  logic [AW-1:0] gap;

  always_comb begin
    biased     = rd_ptr + PTR_BIAS;
    rd_off     = biased[AW-1:0] & mask;
    gap        = (rd_off - wptr) & mask;
    empty      = (rd_off == wptr);
    free_bytes = (gap == '0) ? ring_len : {1'b0, gap};
  end

endmodule

// File: rtl/rxr_lane.sv
module rxr_lane (
  input  logic [31:0] acc,
  input  logic [7:0]  din,
  input  logic [1:0]  lane,
  output logic [31:0] word,
  output logic [3:0]  be
);

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign word[8*i +: 8] = (lane == 2'(i)) ? din : acc[8*i +: 8];
    assign be[i]          = (2'(i) <= lane);
  end

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int unsigned RING_MIN_LOG = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_en,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  input  logic        rdp_we,
  input  logic [15:0] rdp_wdata,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic [4:0]  in_err,
  input  logic        in_bcast,
  input  logic        in_phys,
  input  logic        in_mcast,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  output logic [15:0] rd_ptr,
  output logic [15:0] wr_ptr,
  output logic        buf_empty,
  output logic        ovf_irq,
  output logic [15:0] miss_count
);

  localparam int unsigned AW = RING_MIN_LOG + 3;

  rxr_state_e    state;
  logic [AW-1:0] wptr;
  logic [15:0]   cnt;
  logic [31:0]   acc;
  logic [15:0]   hdr_len;
  logic [15:0]   hdr_status;

  logic [3:0]    accept;
  logic [AW-1:0] mask;
  logic [AW:0]   ring_len;
  logic [AW:0]   free_bytes;
  logic [31:0]   lane_word;
  logic [3:0]    lane_be;

  logic          fire;
  logic          accepted;
  logic          word_end;
  logic [17:0]   woff;
  logic          word_fit;
  logic          hdr_fit;
  logic [AW-1:0] daddr;
  logic [17:0]   step;
  logic [AW-1:0] next_wptr;

  rxr_cfg #(.MIN_LOG(RING_MIN_LOG)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .rdp_we    (rdp_we),
    .rdp_wdata (rdp_wdata),
    .accept    (accept),
    .mask      (mask),
    .ring_len  (ring_len),
    .rd_ptr    (rd_ptr)
  );

  rxr_space #(.AW(AW)) u_space (
    .rd_ptr     (rd_ptr),
    .wptr       (wptr),
    .mask       (mask),
    .ring_len   (ring_len),
    .free_bytes (free_bytes),
    .empty      (buf_empty)
  );

  rxr_lane u_lane (
    .acc  (acc),
    .din  (in_data),
    .lane (cnt[1:0]),
    .word (lane_word),
    .be   (lane_be)
  );

  always_comb begin
    in_ready  = rx_en && (state == ST_DATA || state == ST_DROP);
    fire      = in_valid && in_ready;
    accepted  = accept[ACC_ALL]
              | (accept[ACC_PHYS]  & in_phys)
              | (accept[ACC_MCAST] & in_mcast)
              | (accept[ACC_BCAST] & in_bcast);
    word_end  = (cnt[1:0] == 2'd3) || in_last;
    woff      = 18'd4 + {2'b00, cnt[15:2], 2'b00};
    word_fit  = (woff + 18'd4) < 18'(free_bytes);
    hdr_fit   = 18'd4 < 18'(free_bytes);
    daddr     = (wptr + woff[AW-1:0]) & mask;
    step      = 18'd4 + ((18'(hdr_len) + 18'd3) & ~18'd3);
    next_wptr = (wptr + step[AW-1:0]) & mask;
    wr_ptr    = 16'(wptr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      wptr       <= '0;
      cnt        <= '0;
      acc        <= '0;
      hdr_len    <= '0;
      hdr_status <= '0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      mem_be     <= '0;
      ovf_irq    <= 1'b0;
      miss_count <= '0;
    end else begin
      mem_we  <= 1'b0;
      ovf_irq <= 1'b0;
      if (!rx_en) begin
        state <= ST_IDLE;
        wptr  <= '0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (in_valid) begin
              cnt <= '0;
              if (hdr_fit) begin
                mem_we    <= 1'b1;
                mem_addr  <= 16'(wptr);
                mem_wdata <= {LEN_BUSY, 16'h0000};
                mem_be    <= 4'hF;
                state     <= ST_DATA;
              end else begin
                ovf_irq    <= 1'b1;
                miss_count <= miss_count + 1'b1;
                state      <= ST_DROP;
              end
            end
          end
          ST_DATA: begin
            if (fire) begin
              acc <= lane_word;
              cnt <= cnt + 1'b1;
              if (word_end) begin
                if (word_fit) begin
                  mem_we    <= 1'b1;
                  mem_addr  <= 16'(daddr);
                  mem_wdata <= lane_word;
                  mem_be    <= lane_be;
                  if (in_last) begin
                    if (accepted) begin
                      hdr_len    <= cnt + 1'b1;
                      hdr_status <= make_status(in_err, in_bcast, in_phys, in_mcast);
                      state      <= ST_HDR;
                    end else begin
                      state <= ST_IDLE;
                    end
                  end
                end else begin
                  ovf_irq    <= 1'b1;
                  miss_count <= miss_count + 1'b1;
                  state      <= in_last ? ST_IDLE : ST_DROP;
                end
              end
            end
          end
          ST_DROP: begin
            if (fire && in_last) state <= ST_IDLE;
          end
          ST_HDR: begin
            mem_we    <= 1'b1;
            mem_addr  <= 16'(wptr);
            mem_wdata <= {hdr_len, hdr_status};
            mem_be    <= 4'hF;
            wptr      <= next_wptr;
            state     <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_en,
  input logic        in_ready,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [15:0] wr_ptr,
  input logic        ovf_irq,
  input logic [15:0] miss_count
);

  AST_MEM_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[1:0] == 2'b00)); // R3

  AST_WPTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr[1:0] == 2'b00); // R6

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (wr_ptr == 16'd0)); // R10

  AST_NO_READY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !in_ready); // R10

  AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> (miss_count == $past(miss_count) + 16'd1)); // R9

  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_irq |-> $stable(miss_count)); // R9

  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |=> !ovf_irq); // R9

endmodule

bind rx_ring_writer rx_ring_writer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_en      (rx_en),
  .in_ready   (in_ready),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .wr_ptr     (wr_ptr),
  .ovf_irq    (ovf_irq),
  .miss_count (miss_count)
);

// File: tb/rx_ring_writer_test.sv
`timescale 1ns/1ps
module rx_ring_writer_test;

  localparam int MIN_LOG = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        rdp_we = 1'b0;
  logic [15:0] rdp_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic [4:0]  in_err = '0;
  logic        in_bcast = 1'b0;
  logic        in_phys = 1'b0;
  logic        in_mcast = 1'b0;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  logic [15:0] rd_ptr;
  logic [15:0] wr_ptr;
  logic        buf_empty;
  logic        ovf_irq;
  logic [15:0] miss_count;

  always #10 clk = ~clk;

  rx_ring_writer #(.RING_MIN_LOG(MIN_LOG)) uut (.*);

  logic [7:0] mem [0:511];
  always @(posedge clk) begin
    if (mem_we) begin
      for (int k = 0; k < 4; k++)
        if (mem_be[k]) mem[(int'(mem_addr) + k) % 512] <= mem_wdata[8*k +: 8];
    end
  end

  int ovf_seen = 0;
  always @(posedge clk) if (rst_n && ovf_irq) ovf_seen++;

  int checks = 0;
  int errors = 0;
  int exp_w = 0;
  int ring_l = 64;
  int exp_miss = 0;
  logic [15:0] rdreg = 16'hFFF0;
  logic [3:0]  acc_mask = 4'h0;
  logic [7:0]  fb [0:63];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_status(input logic [4:0] e, input logic b,
                                             input logic p, input logic m);
    return {m, p, b, 7'd0, e, (e == 5'd0)};
  endfunction

  function automatic int rd_off();
    return (int'(rdreg) + 16) % 65536 % ring_l;
  endfunction

  function automatic int free_now();
    int g;
    g = (rd_off() - exp_w + ring_l) % ring_l;
    return (g == 0) ? ring_l : g;
  endfunction

  task automatic host_read(input logic [15:0] v);
    @(negedge clk);
    rdp_we = 1'b1; rdp_wdata = v;
    @(negedge clk);
    rdp_we = 1'b0;
    rdreg = v;
  endtask

  task automatic setup(input int code, input logic [3:0] acc);
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk); rx_en = 1'b1;
    cfg_we = 1'b1; cfg_wdata = 16'((code << 11) | int'(acc));
    @(negedge clk); cfg_we = 1'b0;
    ring_l = 64 << code;
    acc_mask = acc;
    exp_w = 0;
    host_read(16'hFFF0);
  endtask

  task automatic send_frame(input int len, input logic [4:0] e, input logic b,
                            input logic p, input logic m, input bit peek);
    int need, fr, w0;
    bit acc_ok;
    logic [15:0] st;
    w0 = exp_w;
    fr = free_now();
    need = 4 + ((len + 3) & ~3);
    acc_ok = acc_mask[0] | (acc_mask[1] & p) | (acc_mask[2] & m) | (acc_mask[3] & b);
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = fb[i]; in_last = (i == len - 1);
      in_err = e; in_bcast = b; in_phys = p; in_mcast = m;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      if (peek && i == 1) begin
        @(negedge clk); in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 busy len lo", int'(mem[(w0 + 2) % ring_l]), 'hF0);
        check("R2 busy len hi", int'(mem[(w0 + 3) % ring_l]), 'hFF);
      end
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    repeat (4) @(negedge clk);
    if (need >= fr) begin
      exp_miss++;
    end else if (acc_ok) begin
      st = exp_status(e, b, p, m);
      check("R5 status lo", int'(mem[w0]), int'(st[7:0]));
      check("R5 status hi", int'(mem[w0 + 1]), int'(st[15:8]));
      check("R4 len lo", int'(mem[w0 + 2]), len & 255);
      check("R4 len hi", int'(mem[w0 + 3]), len >> 8);
      for (int i = 0; i < len; i++)
        check("R3 data", int'(mem[(w0 + 4 + i) % ring_l]), int'(fb[i]));
      exp_w = (w0 + need) % ring_l;
    end
    check("R6 wr_ptr", int'(wr_ptr), exp_w);
    check("R9 miss_count", int'(miss_count), exp_miss);
    check("R9 ovf pulses", ovf_seen, exp_miss);
    check("R7 buf_empty", int'(buf_empty), int'(rd_off() == exp_w));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R7 reset rd_ptr", int'(rd_ptr), 'hFFF0);
    check("R6 reset wr_ptr", int'(wr_ptr), 0);
    check("R7 reset empty", int'(buf_empty), 1);
    check("R9 reset miss", int'(miss_count), 0);
    check("R10 reset ready", int'(in_ready), 0);
    rst_n = 1'b1;

    // Directed: 64-byte ring, accept all, exact-fit boundaries
    setup(0, 4'b0001);
    send_frame(56, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1); // stored, W=60
    send_frame(1, 5'd3, 1'b0, 1'b1, 1'b0, 1'b0);  // free 4: missed
    host_read(16'(exp_w - 16));                    // drain
    send_frame(59, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0); // need 64: missed
    send_frame(8, 5'd21, 1'b0, 1'b1, 1'b1, 1'b0); // wraps, W -> 8
    check("R1 wrap wr_ptr", int'(wr_ptr), 8);

    // Filter: physical only
    setup(1, 4'b0010);
    send_frame(10, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0); // R8 dropped
    check("R8 dropped keeps ptr", int'(wr_ptr), 0);
    send_frame(10, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0); // stored
    // R10: disable clears pointer, cfg write ignored while disabled
    @(negedge clk); rx_en = 1'b0; cfg_we = 1'b1; cfg_wdata = 16'h0000;
    @(negedge clk); cfg_we = 1'b0;
    check("R10 ready low off", int'(in_ready), 0);
    rx_en = 1'b1;
    @(negedge clk);
    check("R10 wr_ptr cleared", int'(wr_ptr), 0);
    exp_w = 0;
    send_frame(12, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0); // still stored (R10)
    check("R10 cfg kept", int'(wr_ptr), 16);

    // Random epochs
    for (int ep = 0; ep < 8; ep++) begin
      setup(int'($urandom % 4), 4'($urandom));
      for (int f = 0; f < 12; f++) begin
        send_frame(1 + int'($urandom % 60), 5'($urandom % 3 == 0 ? $urandom : 0),
                   1'($urandom), 1'($urandom), 1'($urandom), 1'b0);
        if ($urandom % 2 == 0) host_read(16'(exp_w - 16));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule